// File: doc/BRIEF.md
# LCD Text Cursor Wrap Manager

This block sits between a character source and a nibble bus engine that drives a character LCD. It takes a stream of requests, each either a character byte or a request to place the cursor at a given row and column. It turns each request into one or two byte writes toward the engine. Every byte write is flagged as a command (register select low) or as display data (register select high).

The block keeps no column counter of its own. Before each byte write it asks the engine for a status read and repeats the read while the display reports busy. The address counter returned by the first status read of a character request decides whether the cursor sits just past the end of a line. If it does, a cursor-placement command is sent before the character. The second display line starts at address 0x40. One-line and two-line displays are selected by a parameter, and the visible column count is also a parameter. The newline byte moves the cursor to the start of a line and writes no data.

Top module: `lcdwrap_top`

## Requirements
- R1: `req_ready` is high only when no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The next request is not taken until every byte write of the current one has been accepted, and each request yields exactly the writes listed in R3 to R9.
- R2: After a request is taken, `st_rd` is raised and held. A `st_done` pulse with `st_busy` = 1 keeps the block polling. A byte write is presented only after a `st_done` pulse with `st_busy` = 0, and each byte write of a request has its own poll.
- R3: A cursor-placement request (`req_goto` = 1) produces one command write (`wr_rs` = 0) of code 0x80 + column. The code becomes 0x80 + 0x40 + column when LINES = 2 and `req_row` = 1. With LINES = 1, `req_row` is ignored.
- R4: A requested column equal to or greater than COLS is replaced by COLS-1.
- R5: With LINES = 2, the character 0x0A produces one command write: 0xC0 if the polled address is below 64, otherwise 0x80. No data write follows.
- R6: With LINES = 1, the character 0x0A produces one command write 0x80 and no data write.
- R7: Any other character, where no wrap applies, produces one data write (`wr_rs` = 1) whose code is the character.
- R8: With LINES = 2, a character polled at address COLS is preceded by command 0xC0. A character polled at address 64+COLS is preceded by command 0x80. The data write then follows.
- R9: With LINES = 1, a character polled at address COLS is preceded by command 0x80, then written as data.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_rs` and `wr_code` hold their values into the next cycle.
- R11: While and right after `rst` is high, `req_ready` = 1, `st_rd` = 0 and `wr_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_goto | input | 1 | 1 = cursor placement, 0 = character |
| req_char | input | 8 | Character byte (0x0A = newline) |
| req_col | input | 7 | Requested column for placement |
| req_row | input | 1 | Requested row for placement (0 or 1) |
| st_rd | output | 1 | Status read wanted, held until a non-busy result |
| st_done | input | 1 | One-cycle pulse: status result valid |
| st_busy | input | 1 | Busy flag of the status result |
| st_ac | input | 7 | Address counter of the status result |
| wr_valid | output | 1 | Byte write offered to the engine |
| wr_ready | input | 1 | Engine takes the byte write |
| wr_rs | output | 1 | 0 = command, 1 = display data |
| wr_code | output | 8 | Byte to write |

## Verification
Placement requests are sent with columns inside the range, at the edge and far beyond it, and with both row values. This separates the row offset, the clamp, and the row being ignored on a one-line display. Runs of printable characters longer than a line cross the address COLS on the first line and 64+COLS on the second. This shows the wrap command comes before the data and goes to the right line. Newlines are sent with the cursor on each line to tell the two newline targets apart. The engine model stalls write acceptance and reports busy twice before every write, so the hold rule and the per-write polling are exercised on every transaction.

// File: rtl/lcdwrap_pkg.sv
`timescale 1ns/1ps
package lcdwrap_pkg;

    localparam int AC_W = 7;
    localparam logic [7:0] NEWLINE_CODE = 8'h0A;
    localparam logic [7:0] PLACE_BASE = 8'h80;
    localparam logic [7:0] ROW1_OFFSET = 8'h40;
    localparam logic [AC_W-1:0] ROW1_START = 7'h40;

    typedef struct packed {
        logic            is_goto;
        logic [7:0]      ch;
        logic [AC_W-1:0] col;
        logic            row;
    } lcd_req_t;

    typedef struct packed {
        logic       rs;
        logic [7:0] code;
    } lcd_wr_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_POLL  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_t;

    function automatic lcd_wr_t place_cmd(input logic second_row, input logic [AC_W-1:0] col);
        lcd_wr_t w;
        w.rs   = 1'b0;
        w.code = PLACE_BASE + (second_row ? ROW1_OFFSET : 8'h00) + {1'b0, col};
        return w;
    endfunction

    function automatic lcd_wr_t data_wr(input logic [7:0] ch);
        lcd_wr_t w;
        w.rs   = 1'b1;
        w.code = ch;
        return w;
    endfunction

endpackage

// File: rtl/lcdwrap_plan.sv
`timescale 1ns/1ps
module lcdwrap_plan
    import lcdwrap_pkg::*;
#(
    parameter int LINES = 2,
    parameter int COLS  = 16
) (
    input  lcd_req_t        req,
    input  logic [AC_W-1:0] ac,
    output lcd_wr_t         first_wr,
    output lcd_wr_t         second_wr,
    output logic            two_writes
);
    localparam logic [AC_W-1:0] LAST_COL  = AC_W'(COLS - 1);
    localparam logic [AC_W-1:0] END_ROW0  = AC_W'(COLS);
    localparam logic [AC_W-1:0] END_ROW1  = AC_W'(64 + COLS);
    localparam logic [AC_W-1:0] ZERO_COL  = '0;

    logic [AC_W-1:0] col_lim;
    logic            row_pick;
    logic            nl_target_row1;
    logic            wrap_now;
    logic            wrap_to_row1;

    assign col_lim = (req.col >= END_ROW0) ? LAST_COL : req.col;

    generate
        if (LINES == 2) begin : g_two_rows
            assign row_pick       = req.row;
            assign nl_target_row1 = (ac < ROW1_START);
            assign wrap_to_row1   = (ac == END_ROW0);
            assign wrap_now       = (ac == END_ROW0) || (ac == END_ROW1);
        end else begin : g_one_row
            assign row_pick       = 1'b0;
            assign nl_target_row1 = 1'b0;
            assign wrap_to_row1   = 1'b0;
            assign wrap_now       = (ac == END_ROW0);
        end
    endgenerate

    always_comb begin
        second_wr  = data_wr(req.ch);
        two_writes = 1'b0;
        if (req.is_goto) begin
            first_wr = place_cmd(row_pick, col_lim);
        end else if (req.ch == NEWLINE_CODE) begin
            first_wr = place_cmd(nl_target_row1, ZERO_COL);
        end else if (wrap_now) begin
            first_wr   = place_cmd(wrap_to_row1, ZERO_COL);
            two_writes = 1'b1;
        end else begin
            first_wr = data_wr(req.ch);
        end
    end

    // R8/R9: a wrap always puts a command ahead of the character
    always_comb begin
        if (two_writes) begin
            assert_wrap_order_R8: assert (!first_wr.rs && second_wr.rs && first_wr.code[6:0] == 7'h00 || first_wr.code[6:0] == 7'h40);
        end
    end

endmodule

// File: rtl/lcdwrap_seq.sv
`timescale 1ns/1ps
module lcdwrap_seq
    import lcdwrap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  lcd_req_t        req_in,
    output logic            req_ready,
    output logic            st_rd,
    input  logic            st_done,
    input  logic            st_busy,
    input  logic [AC_W-1:0] st_ac,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic            wr_rs,
    output logic [7:0]      wr_code,
    input  lcd_wr_t         first_wr,
    input  lcd_wr_t         second_wr,
    input  logic            two_writes,
    output lcd_req_t        hold_req,
    output logic [AC_W-1:0] hold_ac
);
    seq_state_t state;
    logic       ac_taken;
    logic       stage;
    lcd_wr_t    cur_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            ac_taken <= 1'b0;
            stage    <= 1'b0;
            hold_req <= '0;
            hold_ac  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        hold_req <= req_in;
                        ac_taken <= 1'b0;
                        stage    <= 1'b0;
                        state    <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (st_done && !st_busy) begin
                        if (!ac_taken) begin
                            hold_ac  <= st_ac;
                            ac_taken <= 1'b1;
                        end
                        state <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (wr_ready) begin
                        if (!stage && two_writes) begin
                            stage <= 1'b1;
                            state <= SQ_POLL;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cur_wr    = stage ? second_wr : first_wr;
    assign req_ready = (state == SQ_IDLE);
    assign st_rd     = (state == SQ_POLL);
    assign wr_valid  = (state == SQ_WRITE);
    assign wr_rs     = cur_wr.rs;
    assign wr_code   = cur_wr.code;

    // R2: a taken request starts with a status poll, not a write
    assert_poll_first_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (st_rd && !wr_valid));

    // R2: a write only appears right after a non-busy status result
    assert_write_after_free_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(st_done && !st_busy));

    // R10: an offered write is held until taken
    assert_write_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_code) && $stable(wr_rs)));

    // R1: no new request taken while a write is still pending
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> !req_ready);

endmodule

// File: rtl/lcdwrap_top.sv
`timescale 1ns/1ps
module lcdwrap_top
    import lcdwrap_pkg::*;
#(
    parameter int LINES = 2,
    parameter int COLS  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_goto,
    input  logic [7:0]  req_char,
    input  logic [6:0]  req_col,
    input  logic        req_row,
    output logic        st_rd,
    input  logic        st_done,
    input  logic        st_busy,
    input  logic [6:0]  st_ac,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic        wr_rs,
    output logic [7:0]  wr_code
);
    lcd_req_t        req_in;
    lcd_req_t        hold_req;
    logic [AC_W-1:0] hold_ac;
    lcd_wr_t         first_wr;
    lcd_wr_t         second_wr;
    logic            two_writes;

    assign req_in.is_goto = req_goto;
    assign req_in.ch      = req_char;
    assign req_in.col     = req_col;
    assign req_in.row     = req_row;

    lcdwrap_plan #(
        .LINES (LINES),
        .COLS  (COLS)
    ) u_plan (
        .req        (hold_req),
        .ac         (hold_ac),
        .first_wr   (first_wr),
        .second_wr  (second_wr),
        .two_writes (two_writes)
    );

    lcdwrap_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .req_ready  (req_ready),
        .st_rd      (st_rd),
        .st_done    (st_done),
        .st_busy    (st_busy),
        .st_ac      (st_ac),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_rs      (wr_rs),
        .wr_code    (wr_code),
        .first_wr   (first_wr),
        .second_wr  (second_wr),
        .two_writes (two_writes),
        .hold_req   (hold_req),
        .hold_ac    (hold_ac)
    );

    // R4: a placement command never points past the last column
    assert_goto_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && hold_req.is_goto) |-> (!wr_rs && wr_code[7] && ({1'b0, wr_code[5:0]} < 7'(COLS))));

    // R8: a taken wrap command is followed by a fresh poll before the data
    assert_wrap_repoll_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !wr_rs && !hold_req.is_goto && hold_req.ch != NEWLINE_CODE) |=> st_rd);

    // R5/R6: a newline never yields a data write
    assert_newline_nodata_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !hold_req.is_goto && hold_req.ch == NEWLINE_CODE) |-> !wr_rs);

endmodule

// File: tb/lcdwrap_top_bench.sv
`timescale 1ns/1ps
module lcdwrap_env #(
    parameter int LINES = 2,
    parameter int COLS  = 16
) (
    input logic clk,
    input logic rst
);
    logic       req_valid, req_ready, req_goto, req_row;
    logic [7:0] req_char;
    logic [6:0] req_col;
    logic       st_rd, st_done, st_busy;
    logic [6:0] st_ac;
    logic       wr_valid, wr_ready, wr_rs;
    logic [7:0] wr_code;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    int    ac        = 0;
    int    busy_left = 0;
    int    lat       = 1;
    int    cyc       = 0;
    bit    free_seen = 0;
    bit    prev_hold = 0;
    logic [8:0] prev_word = '0;

    lcdwrap_top #(.LINES(LINES), .COLS(COLS)) u_lcdwrap_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_goto(req_goto),
        .req_char(req_char), .req_col(req_col), .req_row(req_row),
        .st_rd(st_rd), .st_done(st_done), .st_busy(st_busy), .st_ac(st_ac),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_rs(wr_rs), .wr_code(wr_code)
    );

    task automatic tally(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s (LINES=%0d): actual %0h expected %0h", tag, LINES, act, expv);
        end
    endtask

    task automatic expect_wr(input logic rs, input int code, input string tag);
        exp_q.push_back({rs, 8'(code)});
        tag_q.push_back(tag);
    endtask

    task automatic plan_expect(input bit g, input logic [7:0] ch, input int col, input bit row);
        if (g) begin
            int c;
            c = (col >= COLS) ? COLS - 1 : col;
            expect_wr(1'b0, 'h80 + ((LINES == 2 && row) ? 'h40 : 0) + c, (col >= COLS) ? "R4" : "R3");
        end else if (ch == 8'h0A) begin
            if (LINES == 1) expect_wr(1'b0, 'h80, "R6");
            else expect_wr(1'b0, (ac < 64) ? 'hC0 : 'h80, "R5");
        end else begin
            if (LINES == 2 && ac == COLS) expect_wr(1'b0, 'hC0, "R8");
            else if (LINES == 2 && ac == 64 + COLS) expect_wr(1'b0, 'h80, "R8");
            else if (LINES == 1 && ac == COLS) expect_wr(1'b0, 'h80, "R9");
            expect_wr(1'b1, ch, "R7");
        end
    endtask

    // engine model: status replies, write acceptance, address counter
    always @(negedge clk) begin
        if (rst) begin
            wr_ready = 1'b0; st_done = 1'b0; st_busy = 1'b0; st_ac = '0;
            lat = 1; prev_hold = 0;
        end else begin
            cyc++;
            if (prev_hold)
                tally(wr_valid && ({wr_rs, wr_code} == prev_word), "R10", {wr_valid, wr_rs, wr_code}, {1'b1, prev_word});
            wr_ready = (cyc % 3) != 2;
            st_done  = 1'b0;
            if (st_rd) begin
                if (lat == 0) begin
                    st_done = 1'b1;
                    st_busy = (busy_left > 0);
                    st_ac   = 7'(ac);
                    if (busy_left > 0) busy_left--;
                    else free_seen = 1;
                    lat = 1;
                end else begin
                    lat--;
                end
            end
            if (wr_valid && wr_ready) begin
                tally(free_seen, "R2", 0, 1);
                free_seen = 0;
                if (exp_q.size() == 0) begin
                    tally(0, "R1", {wr_rs, wr_code}, 0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    tally({wr_rs, wr_code} == e, t, {wr_rs, wr_code}, e);
                end
                if (!wr_rs) ac = wr_code & 8'h7F;
                else ac = (ac + 1) & 'h7F;
                busy_left = 2;
            end
            prev_hold = wr_valid && !wr_ready;
            prev_word = {wr_rs, wr_code};
        end
    end

    task automatic send(input bit g, input logic [7:0] ch, input int col, input bit row);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        plan_expect(g, ch, col, row);
        req_goto = g; req_char = ch; req_col = 7'(col); req_row = row;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tally(exp_q.size() == 0, "R1", exp_q.size(), 0);
    endtask

    initial begin
        req_valid = 0; req_goto = 0; req_char = 0; req_col = 0; req_row = 0;
        @(negedge clk);
        tally(req_ready && !st_rd && !wr_valid, "R11", {req_ready, st_rd, wr_valid}, 3'b100);
        while (rst) @(negedge clk);
        tally(req_ready && !st_rd && !wr_valid, "R11", {req_ready, st_rd, wr_valid}, 3'b100);
        send(1, 8'h00, 0, 0);
        send(1, 8'h00, 5, 1);
        send(1, 8'h00, COLS - 1, 0);
        send(1, 8'h00, 30, 0);
        send(1, 8'h00, 99, 1);
        send(1, 8'h00, 0, 0);
        for (int i = 0; i < 20; i++) send(0, 8'(8'h41 + i), 0, 0);
        send(0, 8'h0A, 0, 0);
        send(0, 8'h0A, 0, 0);
        for (int i = 0; i < 17; i++) send(0, 8'(8'h61 + i), 0, 0);
        send(1, 8'h00, 3, 1);
        send(0, 8'h0A, 0, 0);
        send(0, 8'h5A, 0, 0);
        done = 1;
    end
endmodule

module lcdwrap_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;

    always #2.5 clk = ~clk;

    lcdwrap_env #(.LINES(2), .COLS(16)) u_env_two (.clk(clk), .rst(rst));
    lcdwrap_env #(.LINES(1), .COLS(16)) u_env_one (.clk(clk), .rst(rst));

    initial begin
        int checks;
        int fails;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 50000 && !(u_env_two.done && u_env_one.done); i++) @(posedge clk);
        checks = u_env_two.n_checks + u_env_one.n_checks;
        fails  = u_env_two.n_fails + u_env_one.n_fails;
        if (!(u_env_two.done && u_env_one.done)) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule